// File: doc/BRIEF.md
# Thermal Limit Monitor

This block is the digital half of a temperature sensing device. It asks an external converter for samples over a start/done handshake. Each returned sample is stored and compared, as a signed 8-bit value, against a high limit and a low limit. A violation sets a sticky status bit and drives an active-low alert pin. The alert is a level that follows the status bits. It is not tied to any bus transaction.

A register port carries a command code, a write flag and a data byte, the shape a serial management-bus front end would drive. Through it a host reads the last sample and the status, and reads or writes the configuration, the rate code and both limits.

Conversions start in two ways. A free-running scheduler counts an external tick. Its interval is picked from a three-bit rate code and halves with each step of the code. A one-shot command starts a conversion at once. A one-shot that arrives during a conversion is remembered and runs after it. A standby bit stops the scheduler, while one-shots still work.

Top module: `thermMon`

## Requirements
- R1: After reset alertN is 1 and convStart is 0. Reads return: temperature 0x00, status 0x00, configuration 0x00, rate code 4, high limit 0x55, low limit 0xC9.
- R2: A read command (cmdValid=1, cmdWrite=0) puts the addressed register on rdData after the next rising edge. The codes are 0x00 temperature, 0x01 status, 0x02 configuration (bit 0 = standby), 0x03 rate code, 0x04 high limit and 0x05 low limit. Codes 0x02 to 0x05 are writable.
- R3: A completed sample that is greater than or equal to the high limit (signed compare) sets status bit 0 and drives alertN low. A sample below the limit does neither.
- R4: A completed sample that is less than or equal to the low limit (signed compare) sets status bit 1 and drives alertN low. A sample above the limit does neither.
- R5: Status bits 0 and 1 stay set until the status register is read. The read returns the bits and then clears them. alertN returns to 1 only when both bits are clear. Status bit 7 is 1 while a conversion is in flight.
- R6: Command code 0x0F (one-shot) asserts convStart for exactly one cycle, starting after the edge that takes the command, provided no conversion is in flight.
- R7: A one-shot taken while a conversion is in flight does not disturb that conversion. Exactly one more conversion starts after convDone, however many one-shots arrived.
- R8: With standby clear, an automatic conversion starts after (16 × TICKS_PER_SEC) >> code tick pulses, counted from the last write of the rate code or the configuration.
- R9: A rate code write with a value above 7 stores 7.
- R10: With standby set, no automatic conversion starts, but one-shot conversions still do.
- R11: convDone while no conversion is in flight is ignored. The temperature register and the alert are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Timebase pulse, TICKS_PER_SEC per second |
| cmdValid | input | 1 | Command present this cycle |
| cmdWrite | input | 1 | 1 = write, 0 = read |
| cmdCode | input | 8 | Register or command code |
| cmdWdata | input | 8 | Write data |
| rdData | output | 8 | Read data, registered |
| convStart | output | 1 | One-cycle request to the converter |
| convDone | input | 1 | Converter result valid |
| convData | input | 8 | Converter result, two's complement |
| alertN | output | 1 | Active-low limit alert |

## Verification
Take P as the edge that accepts a command. Read data and the convStart pulse of a one-shot are both valid in the cycle after P. The bench samples each of them at the falling edge that follows P. A sample is loaded at the edge that takes convDone, so the alert and status change one cycle later, and the bench checks them at the next falling edge. After a completed conversion with a one-shot pending, the replacement convStart comes two edges after convDone. For that reason the bench counts start pulses over a window of several cycles rather than probing one cycle. An automatic start follows the edge that samples the final tick, and the bench checks it at the falling edge where that tick is dropped.

// File: rtl/thermPkg.sv
`timescale 1ns/1ps
package thermPkg;
  localparam logic [7:0] CMD_TEMP    = 8'h00;
  localparam logic [7:0] CMD_STATUS  = 8'h01;
  localparam logic [7:0] CMD_CFG     = 8'h02;
  localparam logic [7:0] CMD_RATE    = 8'h03;
  localparam logic [7:0] CMD_HIGH    = 8'h04;
  localparam logic [7:0] CMD_LOW     = 8'h05;
  localparam logic [7:0] CMD_ONESHOT = 8'h0F;

  typedef enum logic {ST_IDLE, ST_BUSY} convStateT;

  typedef struct packed {
    logic loadSample;
    logic wrHigh;
    logic wrLow;
    logic clrStatus;
    logic rdEn;
  } strobeT;
endpackage

// File: rtl/thermCtrl.sv
`timescale 1ns/1ps
module thermCtrl
  import thermPkg::*;
#(
  parameter int DATA_W        = 8,
  parameter int TICKS_PER_SEC = 16,
  parameter int RATE_MAX      = 7,
  parameter int RATE_RST      = 4,
  localparam int RATE_W       = $clog2(RATE_MAX + 1),
  localparam int BASE_TICKS   = 16 * TICKS_PER_SEC,
  localparam int CNT_W        = $clog2(BASE_TICKS + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick,
  input  logic              cmdValid,
  input  logic              cmdWrite,
  input  logic [7:0]        cmdCode,
  input  logic [DATA_W-1:0] cmdWdata,
  input  logic              convDone,
  output logic              convStart,
  output strobeT            strobe,
  output logic              cfgStandby,
  output logic [RATE_W-1:0] rateCode,
  output logic              busy
);
  convStateT   state;
  logic        pend;
  logic        wrEn, rdReq, oneShot, rateWr, cfgWr, autoReq, startNow;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] intervalTab [RATE_MAX+1];
  logic [CNT_W-1:0] intervalM1;

  assign wrEn    = cmdValid && cmdWrite;
  assign rdReq   = cmdValid && !cmdWrite;
  assign oneShot = cmdValid && (cmdCode == CMD_ONESHOT);
  assign rateWr  = wrEn && (cmdCode == CMD_RATE);
  assign cfgWr   = wrEn && (cmdCode == CMD_CFG);

  // Interval per rate code: base period halved once per code step
  for (genvar g = 0; g <= RATE_MAX; g++) begin : gInterval
    assign intervalTab[g] = CNT_W'(BASE_TICKS >> g);
  end
  assign intervalM1 = intervalTab[rateCode] - CNT_W'(1);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgStandby <= 1'b0;
      rateCode   <= RATE_W'(RATE_RST);
    end else begin
      if (cfgWr) cfgStandby <= cmdWdata[0];
      if (rateWr) begin
        if (cmdWdata > DATA_W'(RATE_MAX)) rateCode <= RATE_W'(RATE_MAX);
        else                              rateCode <= cmdWdata[RATE_W-1:0];
      end
    end
  end

  // Auto-convert timebase
  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (rateWr || cfgWr || cfgStandby) begin
      cnt <= '0;
    end else if (tick) begin
      if (cnt >= intervalM1) cnt <= '0;
      else                   cnt <= cnt + CNT_W'(1);
    end
  end

  assign autoReq  = tick && !cfgStandby && !rateWr && !cfgWr && (cnt >= intervalM1);
  assign startNow = (state == ST_IDLE) && (oneShot || pend || autoReq);

  // Conversion sequencing
  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      pend      <= 1'b0;
      convStart <= 1'b0;
    end else begin
      convStart <= startNow;
      if (startNow) begin
        state <= ST_BUSY;
        pend  <= 1'b0;
      end else if (state == ST_BUSY) begin
        if (oneShot)  pend  <= 1'b1;
        if (convDone) state <= ST_IDLE;
      end
    end
  end

  assign busy = (state == ST_BUSY);

  always_comb begin
    strobe            = '0;
    strobe.loadSample = (state == ST_BUSY) && convDone;
    strobe.wrHigh     = wrEn && (cmdCode == CMD_HIGH);
    strobe.wrLow      = wrEn && (cmdCode == CMD_LOW);
    strobe.clrStatus  = rdReq && (cmdCode == CMD_STATUS);
    strobe.rdEn       = rdReq;
  end

  AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    convStart |=> !convStart); // R6
  AST_PEND_RESTART: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_BUSY && convDone && (pend || oneShot)) |=> ##1 convStart); // R7
  AST_STANDBY_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (cfgStandby && state == ST_IDLE && !pend && !oneShot) |=> !convStart); // R10
  AST_IDLE_START: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && oneShot) |=> (convStart && busy)); // R6
endmodule

// File: rtl/thermData.sv
`timescale 1ns/1ps
module thermData
  import thermPkg::*;
#(
  parameter int DATA_W          = 8,
  parameter int RATE_W          = 3,
  parameter logic [7:0] HIGH_RST = 8'h55,
  parameter logic [7:0] LOW_RST  = 8'hC9
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobeT            strobe,
  input  logic [7:0]        cmdCode,
  input  logic [DATA_W-1:0] cmdWdata,
  input  logic [DATA_W-1:0] sample,
  input  logic              cfgStandby,
  input  logic [RATE_W-1:0] rateCode,
  input  logic              busy,
  output logic [DATA_W-1:0] rdData,
  output logic              alertN
);
  logic [DATA_W-1:0] tempReg, highReg, lowReg, statusWord, rdNext;
  logic statHigh, statLow, hitHigh, hitLow;

  assign hitHigh = $signed(sample) >= $signed(highReg);
  assign hitLow  = $signed(sample) <= $signed(lowReg);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tempReg  <= '0;
      highReg  <= DATA_W'(HIGH_RST);
      lowReg   <= DATA_W'(LOW_RST);
      statHigh <= 1'b0;
      statLow  <= 1'b0;
    end else begin
      if (strobe.loadSample) tempReg <= sample;
      if (strobe.wrHigh)     highReg <= cmdWdata;
      if (strobe.wrLow)      lowReg  <= cmdWdata;
      // a fresh violation wins over a clearing read in the same cycle
      if (strobe.loadSample && hitHigh) statHigh <= 1'b1;
      else if (strobe.clrStatus)        statHigh <= 1'b0;
      if (strobe.loadSample && hitLow)  statLow  <= 1'b1;
      else if (strobe.clrStatus)        statLow  <= 1'b0;
    end
  end

  always_comb begin
    statusWord         = '0;
    statusWord[0]      = statHigh;
    statusWord[1]      = statLow;
    statusWord[DATA_W-1] = busy;
  end

  always_comb begin
    case (cmdCode)
      CMD_TEMP:   rdNext = tempReg;
      CMD_STATUS: rdNext = statusWord;
      CMD_CFG:    rdNext = DATA_W'(cfgStandby);
      CMD_RATE:   rdNext = DATA_W'(rateCode);
      CMD_HIGH:   rdNext = highReg;
      CMD_LOW:    rdNext = lowReg;
      default:    rdNext = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN)            rdData <= '0;
    else if (strobe.rdEn) rdData <= rdNext;
  end

  assign alertN = !(statHigh || statLow);

  AST_HIGH_ALERT: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.loadSample && ($signed(sample) >= $signed(highReg))) |=> !alertN); // R3
  AST_LOW_ALERT: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.loadSample && ($signed(sample) <= $signed(lowReg))) |=> !alertN); // R4
  AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (statHigh && !strobe.clrStatus) |=> statHigh); // R5
  AST_CLEAR_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.clrStatus && !strobe.loadSample) |=> alertN); // R5
endmodule

// File: rtl/thermMon.sv
`timescale 1ns/1ps
module thermMon
  import thermPkg::*;
#(
  parameter int DATA_W           = 8,
  parameter int TICKS_PER_SEC    = 16,
  parameter int RATE_MAX         = 7,
  parameter int RATE_RST         = 4,
  parameter logic [7:0] HIGH_RST = 8'h55,
  parameter logic [7:0] LOW_RST  = 8'hC9,
  localparam int RATE_W          = $clog2(RATE_MAX + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick,
  input  logic              cmdValid,
  input  logic              cmdWrite,
  input  logic [7:0]        cmdCode,
  input  logic [DATA_W-1:0] cmdWdata,
  output logic [DATA_W-1:0] rdData,
  output logic              convStart,
  input  logic              convDone,
  input  logic [DATA_W-1:0] convData,
  output logic              alertN
);
  strobeT            strobe;
  logic              cfgStandby, busy;
  logic [RATE_W-1:0] rateCode;

  thermCtrl #(
    .DATA_W(DATA_W), .TICKS_PER_SEC(TICKS_PER_SEC),
    .RATE_MAX(RATE_MAX), .RATE_RST(RATE_RST)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .tick(tick),
    .cmdValid(cmdValid), .cmdWrite(cmdWrite), .cmdCode(cmdCode), .cmdWdata(cmdWdata),
    .convDone(convDone), .convStart(convStart), .strobe(strobe),
    .cfgStandby(cfgStandby), .rateCode(rateCode), .busy(busy)
  );

  thermData #(
    .DATA_W(DATA_W), .RATE_W(RATE_W), .HIGH_RST(HIGH_RST), .LOW_RST(LOW_RST)
  ) data_i (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .cmdCode(cmdCode), .cmdWdata(cmdWdata), .sample(convData),
    .cfgStandby(cfgStandby), .rateCode(rateCode), .busy(busy),
    .rdData(rdData), .alertN(alertN)
  );
endmodule

// File: tb/thermMon_tb_top.sv
`timescale 1ns/1ps
module thermMon_tb_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       tick = 1'b0;
  logic       cmdValid = 1'b0, cmdWrite = 1'b0;
  logic [7:0] cmdCode = '0, cmdWdata = '0;
  logic [7:0] rdData;
  logic       convStart;
  logic       convDone = 1'b0;
  logic [7:0] convData = '0;
  logic       alertN;
  int nChecks = 0;
  int nErr = 0;

  always #2 clk = ~clk;

  thermMon dut_i (
    .clk(clk), .rstN(rstN), .tick(tick), .cmdValid(cmdValid), .cmdWrite(cmdWrite),
    .cmdCode(cmdCode), .cmdWdata(cmdWdata), .rdData(rdData), .convStart(convStart),
    .convDone(convDone), .convData(convData), .alertN(alertN)
  );

  task automatic check(input string req, input int act, input int exp);
    nChecks++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cmd(input logic wr, input logic [7:0] code, input logic [7:0] data);
    @(negedge clk);
    cmdValid = 1'b1; cmdWrite = wr; cmdCode = code; cmdWdata = data;
    @(negedge clk);
    cmdValid = 1'b0; cmdWrite = 1'b0;
  endtask

  task automatic rd(input logic [7:0] code, output logic [7:0] val);
    cmd(1'b0, code, 8'h00);
    val = rdData;
  endtask

  task automatic finishConv(input logic [7:0] d);
    @(negedge clk);
    convDone = 1'b1; convData = d;
    @(negedge clk);
    convDone = 1'b0;
  endtask

  task automatic convert(input string req, input logic [7:0] d);
    for (int k = 0; k < 20 && !convStart; k++) @(negedge clk);
    check(req, convStart, 1);
    finishConv(d);
  endtask

  task automatic pulseTick();
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
  endtask

  task automatic countStarts(input int cycles, output int n);
    n = 0;
    for (int k = 0; k < cycles; k++) begin
      if (convStart) n++;
      @(negedge clk);
    end
  endtask

  task automatic tResetState();
    logic [7:0] v;
    check("R1 alertN", alertN, 1);
    check("R1 convStart", convStart, 0);
    rd(8'h00, v); check("R1 temp", v, 8'h00);
    rd(8'h01, v); check("R1 status", v, 8'h00);
    rd(8'h02, v); check("R1 cfg", v, 8'h00);
    rd(8'h03, v); check("R1 rate", v, 4);
    rd(8'h04, v); check("R1 high", v, 8'h55);
    rd(8'h05, v); check("R1 low", v, 8'hC9);
  endtask

  task automatic tRegs();
    logic [7:0] v;
    cmd(1'b1, 8'h04, 8'h30); rd(8'h04, v); check("R2 high rw", v, 8'h30);
    cmd(1'b1, 8'h05, 8'hF0); rd(8'h05, v); check("R2 low rw", v, 8'hF0);
    cmd(1'b1, 8'h03, 8'h02); rd(8'h03, v); check("R2 rate rw", v, 2);
    cmd(1'b1, 8'h03, 8'hC5); rd(8'h03, v); check("R9 rate clamp", v, 7);
  endtask

  task automatic tOneShot();
    logic [7:0] v;
    cmd(1'b1, 8'h0F, 8'h00);
    check("R6 start pulse", convStart, 1);
    rd(8'h01, v); check("R5 busy bit", v, 8'h80);
    check("R6 single cycle", convStart, 0);
    finishConv(8'h10);
    rd(8'h00, v); check("R2 temp read", v, 8'h10);
    check("R3 no alert mid-range", alertN, 1);
  endtask

  task automatic tLimits();
    logic [7:0] v;
    cmd(1'b1, 8'h0F, 8'h00); convert("R3", 8'h2F);
    check("R3 below high", alertN, 1);
    cmd(1'b1, 8'h0F, 8'h00); convert("R3", 8'h30);
    check("R3 equal high alert", alertN, 0);
    rd(8'h01, v); check("R5 status high", v, 8'h01);
    check("R5 alert released", alertN, 1);
    rd(8'h01, v); check("R5 status cleared", v, 8'h00);
    cmd(1'b1, 8'h0F, 8'h00); convert("R4", 8'h80);
    check("R4 signed low alert", alertN, 0);
    rd(8'h01, v); check("R4 status low", v, 8'h02);
    cmd(1'b1, 8'h0F, 8'h00); convert("R4", 8'hF0);
    check("R4 equal low alert", alertN, 0);
    rd(8'h01, v);
    cmd(1'b1, 8'h0F, 8'h00); convert("R4", 8'hF1);
    check("R4 above low", alertN, 1);
    cmd(1'b1, 8'h0F, 8'h00); convert("R5", 8'h40);
    cmd(1'b1, 8'h0F, 8'h00); convert("R5", 8'h05);
    check("R5 sticky alert", alertN, 0);
    cmd(1'b1, 8'h0F, 8'h00); convert("R5", 8'hEC);
    rd(8'h01, v); check("R5 both bits", v, 8'h03);
    check("R5 both cleared alert", alertN, 1);
  endtask

  task automatic tPending();
    int n;
    cmd(1'b1, 8'h0F, 8'h00);
    check("R7 first start", convStart, 1);
    cmd(1'b1, 8'h0F, 8'h00);
    cmd(1'b1, 8'h0F, 8'h00);
    finishConv(8'h11);
    countStarts(8, n); check("R7 exactly one restart", n, 1);
    finishConv(8'h12);
    countStarts(8, n); check("R7 no extra start", n, 0);
  endtask

  task automatic tIdleDone();
    logic [7:0] v;
    finishConv(8'h70);
    rd(8'h00, v); check("R11 temp unchanged", v, 8'h12);
    check("R11 no alert", alertN, 1);
  endtask

  task automatic tAuto();
    cmd(1'b1, 8'h03, 8'h07);
    pulseTick(); check("R8 code7 tick1", convStart, 0);
    pulseTick(); check("R8 code7 tick2", convStart, 1);
    finishConv(8'h10);
    cmd(1'b1, 8'h03, 8'h06);
    for (int k = 0; k < 3; k++) begin
      pulseTick(); check("R8 code6 early", convStart, 0);
    end
    pulseTick(); check("R8 code6 tick4", convStart, 1);
    finishConv(8'h10);
  endtask

  task automatic tStandby();
    int n = 0;
    cmd(1'b1, 8'h02, 8'h01);
    cmd(1'b1, 8'h03, 8'h07);
    for (int k = 0; k < 5; k++) begin
      pulseTick();
      if (convStart) n++;
    end
    check("R10 no auto in standby", n, 0);
    cmd(1'b1, 8'h0F, 8'h00);
    check("R10 one-shot in standby", convStart, 1);
    finishConv(8'h10);
    cmd(1'b1, 8'h02, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    tResetState();
    tRegs();
    tOneShot();
    tLimits();
    tPending();
    tIdleDone();
    tAuto();
    tStandby();
    $display("CHECKS %0d ERRORS %0d", nChecks, nErr);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++;
    nErr++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", nChecks, nErr);
    $finish;
  end
endmodule